// File: doc/BRIEF.md
# Stackless Hierarchy Traversal State Unit

This block keeps the complete per-ray walk state for a binary bounding-volume tree without a stack. The state is three registers: the path key of the current node, a trail of pending-sibling flags with one bit per level, and a one-entry cache that holds the address of the node postponed most recently. A traversal controller issues one command per cycle. Node commands carry the two child-hit results, which child is closer, both child addresses, and the uncle and grand-uncle references that come with the node record. Leaf commands carry only the uncle and grand-uncle references.

A backtrack command finds the next pending node in a single cycle. A priority encoder counts the trailing zeros of the trail. Key and trail are then both shifted right by that count, and their lowest bit is inverted. If the cache holds an address, that address is reported as the next node and the cache is emptied. Otherwise the new key is reported so that an external hash lookup can turn it into an address. An empty trail at a backtrack point marks the ray finished. A ray can also be restarted from a saved key alone.

Top module: `trav_state_unit`

## Requirements
- R1: After reset or a START command (op_i = 1), key_o is 1, trail_o is 0, pp_valid_o is 0, done_o and ovf_o are 0. key_o is never 0.
- R2: A NODE command (op_i = 2) with at least one child hit shifts key_o left by one. The new bit 0 is 1 when the right child is taken. The right child is taken when only it was hit, or when both were hit and closer_r_i is 1.
- R3: On that descent, trail_o shifts left by one, and its new bit 0 is 1 exactly when both children were hit.
- R4: When both children are hit, the address of the child not taken is written into the postponed cache: left_addr_i when closer_r_i is 1, otherwise right_addr_i. This write replaces any earlier content.
- R5: On a NODE or LEAF (op_i = 3) command with the cache empty and trail bit 1 or bit 2 set, the cache is loaded. It takes uncle_i when trail bit 1 is set, otherwise guncle_i. A cache that already holds an address is left unchanged by these fields.
- R6: A BACK command (op_i = 4) with a nonzero trail takes n as the trailing-zero count of the trail. Both trail and key become (value >> n) xor 1, and bt_valid_o pulses in the cycle that follows. bt_key_o equals the new key.
- R7: If the cache holds an address at that BACK, bt_cached_o is 1, bt_addr_o carries the cached address, and the cache is emptied.
- R8: If the cache is empty at that BACK, bt_cached_o is 0 and bt_key_o carries the key to be looked up.
- R9: A BACK with a zero trail sets done_o and changes neither the key nor the trail. done_o stays set until a START, a RESUME, or a descent.
- R10: A RESUME command (op_i = 5) with a nonzero resume_key_i loads that key and sets every trail bit below the key's leading one. It also empties the cache and clears done_o and ovf_o. A RESUME with a zero key leaves the state unchanged.
- R11: A descent attempted while key bit 31 is set changes neither key, trail nor cache, and sets ovf_o. ovf_o stays set until START or RESUME.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Command: 0 idle, 1 start, 2 node, 3 leaf, 4 back, 5 resume |
| hit_l_i | input | 1 | Left child box hit |
| hit_r_i | input | 1 | Right child box hit |
| closer_r_i | input | 1 | Right child is the closer one |
| left_addr_i | input | 32 | Left child address |
| right_addr_i | input | 32 | Right child address |
| uncle_i | input | 32 | Uncle reference from the node or leaf record |
| guncle_i | input | 32 | Grand-uncle reference from the node or leaf record |
| resume_key_i | input | 32 | Saved key for RESUME |
| key_o | output | 32 | Current node key |
| trail_o | output | 32 | Pending-sibling trail |
| pp_valid_o | output | 1 | Postponed cache holds an address |
| pp_addr_o | output | 32 | Postponed cache address |
| bt_valid_o | output | 1 | One-cycle pulse: a backtrack target is ready |
| bt_cached_o | output | 1 | Target address comes from the cache |
| bt_addr_o | output | 32 | Cached target address |
| bt_key_o | output | 32 | Target key for the hash lookup |
| done_o | output | 1 | Traversal finished |
| ovf_o | output | 1 | Depth overflow seen |

## Verification
Several rules are checked by the assertions on every cycle:
- the left shift of the key on each descent, and the bit the trail gains;
- the capture of the farther child into the cache;
- the drop of exactly one trail bit per backtrack;
- cache consumption on a cached backtrack;
- a done flag that implies an empty trail;
- a frozen key on overflow.

The exact keys reached after multi-level backtracks can only be shown by the bench's scenarios, since they depend on the trailing-zero count. The same holds for the choice between uncle and grand-uncle, the trail mask built on resume, and the ignored zero-key resume.

// File: rtl/trav_pkg.sv
package trav_pkg;
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_START  = 3'd1,
    OP_NODE   = 3'd2,
    OP_LEAF   = 3'd3,
    OP_BACK   = 3'd4,
    OP_RESUME = 3'd5
  } trav_op_e;
endpackage

// File: rtl/trav_ctz.sv
module trav_ctz #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  // Priority encoder: the lowest set bit wins, scanned from the top down.
  always_comb begin
    cnt_o = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) cnt_o = CW'(i);
    end
  end

  assign zero_o = ~|vec_i;
endmodule

// File: rtl/trav_backstep.sv
module trav_backstep #(
  parameter int KW = 32
) (
  input  logic [KW-1:0] key_i,
  input  logic [KW-1:0] trail_i,
  output logic [KW-1:0] key_o,
  output logic [KW-1:0] trail_o,
  output logic          empty_o
);
  localparam int CW = $clog2(KW) + 1;

  logic [CW-1:0] lvls;

  trav_ctz #(.W(KW), .CW(CW)) u_ctz (
    .vec_i  (trail_i),
    .cnt_o  (lvls),
    .zero_o (empty_o)
  );

  function automatic logic [KW-1:0] climb(input logic [KW-1:0] v, input logic [CW-1:0] n);
    return (v >> n) ^ KW'(1);
  endfunction

  assign key_o   = climb(key_i, lvls);
  assign trail_o = climb(trail_i, lvls);
endmodule

// File: rtl/trav_pp_reg.sv
module trav_pp_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [AW-1:0] d_i,
  input  logic          clr_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else if (ld_i) begin
      valid_o <= 1'b1;
      addr_o  <= d_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/trav_state_unit.sv
module trav_state_unit #(
  parameter int KW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_i,
  input  logic          hit_l_i,
  input  logic          hit_r_i,
  input  logic          closer_r_i,
  input  logic [AW-1:0] left_addr_i,
  input  logic [AW-1:0] right_addr_i,
  input  logic [AW-1:0] uncle_i,
  input  logic [AW-1:0] guncle_i,
  input  logic [KW-1:0] resume_key_i,
  output logic [KW-1:0] key_o,
  output logic [KW-1:0] trail_o,
  output logic          pp_valid_o,
  output logic [AW-1:0] pp_addr_o,
  output logic          bt_valid_o,
  output logic          bt_cached_o,
  output logic [AW-1:0] bt_addr_o,
  output logic [KW-1:0] bt_key_o,
  output logic          done_o,
  output logic          ovf_o
);
  import trav_pkg::*;

  function automatic logic [KW-1:0] below_msb(input logic [KW-1:0] k);
    logic [KW-1:0] m;
    m = '0;
    for (int i = 0; i < KW; i++) begin
      if (k[i]) m = (KW'(1) << i) - KW'(1);
    end
    return m;
  endfunction

  logic [KW-1:0] key_q, trail_q;
  logic          done_q, ovf_q;
  logic          btv_q, btc_q;
  logic [AW-1:0] bta_q;
  logic [KW-1:0] btk_q;

  trav_op_e op;
  assign op = trav_op_e'(op_i);

  logic is_node, is_leaf, is_back, is_start, is_resume;
  assign is_node   = (op == OP_NODE);
  assign is_leaf   = (op == OP_LEAF);
  assign is_back   = (op == OP_BACK);
  assign is_start  = (op == OP_START);
  assign is_resume = (op == OP_RESUME);

  // Named events, also used by the checker
  logic any_hit, both_hit, go_right, depth_full;
  logic ev_descend, ev_overflow, ev_postpone, ev_fill, ev_backstep, ev_end, ev_resume;

  assign any_hit     = hit_l_i | hit_r_i;
  assign both_hit    = hit_l_i & hit_r_i;
  assign go_right    = hit_r_i & (~hit_l_i | closer_r_i);
  assign depth_full  = key_q[KW-1];
  assign ev_descend  = is_node & any_hit & ~depth_full;
  assign ev_overflow = is_node & any_hit & depth_full;
  assign ev_postpone = ev_descend & both_hit;
  assign ev_fill     = (is_node | is_leaf) & ~ev_overflow & ~pp_valid_o & (|trail_q[2:1]);
  assign ev_resume   = is_resume & (|resume_key_i);

  logic [KW-1:0] bs_key, bs_trail;
  logic          bs_empty;

  trav_backstep #(.KW(KW)) u_back (
    .key_i   (key_q),
    .trail_i (trail_q),
    .key_o   (bs_key),
    .trail_o (bs_trail),
    .empty_o (bs_empty)
  );

  assign ev_backstep = is_back & ~bs_empty;
  assign ev_end      = is_back & bs_empty;

  logic          pp_ld, pp_clr;
  logic [AW-1:0] pp_d, far_addr, fill_addr;

  assign far_addr  = closer_r_i ? left_addr_i : right_addr_i;
  assign fill_addr = trail_q[1] ? uncle_i : guncle_i;
  assign pp_ld     = ev_postpone | ev_fill;
  assign pp_d      = ev_postpone ? far_addr : fill_addr;
  assign pp_clr    = (ev_backstep & pp_valid_o) | is_start | ev_resume;

  trav_pp_reg #(.AW(AW)) u_pp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_i    (pp_ld),
    .d_i     (pp_d),
    .clr_i   (pp_clr),
    .valid_o (pp_valid_o),
    .addr_o  (pp_addr_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || is_start) begin
      key_q   <= KW'(1);
      trail_q <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (ev_resume) begin
      key_q   <= resume_key_i;
      trail_q <= below_msb(resume_key_i);
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (ev_descend) begin
      key_q   <= {key_q[KW-2:0], go_right};
      trail_q <= {trail_q[KW-2:0], both_hit};
      done_q  <= 1'b0;
    end else if (ev_overflow) begin
      ovf_q   <= 1'b1;
    end else if (ev_backstep) begin
      key_q   <= bs_key;
      trail_q <= bs_trail;
    end else if (ev_end) begin
      done_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      btv_q <= 1'b0;
      btc_q <= 1'b0;
      bta_q <= '0;
      btk_q <= '0;
    end else begin
      btv_q <= ev_backstep;
      btc_q <= ev_backstep & pp_valid_o;
      if (ev_backstep) begin
        bta_q <= pp_valid_o ? pp_addr_o : '0;
        btk_q <= bs_key;
      end
    end
  end

  assign key_o       = key_q;
  assign trail_o     = trail_q;
  assign bt_valid_o  = btv_q;
  assign bt_cached_o = btc_q;
  assign bt_addr_o   = bta_q;
  assign bt_key_o    = btk_q;
  assign done_o      = done_q;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/trav_state_chk.sv
module trav_state_chk #(
  parameter int KW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hit_l_i,
  input logic          hit_r_i,
  input logic          closer_r_i,
  input logic [AW-1:0] left_addr_i,
  input logic [AW-1:0] right_addr_i,
  input logic [KW-1:0] key_o,
  input logic [KW-1:0] trail_o,
  input logic          pp_valid_o,
  input logic [AW-1:0] pp_addr_o,
  input logic          bt_valid_o,
  input logic          bt_cached_o,
  input logic [AW-1:0] bt_addr_o,
  input logic [KW-1:0] bt_key_o,
  input logic          done_o,
  input logic          ovf_o,
  input logic          ev_descend,
  input logic          ev_overflow,
  input logic          ev_backstep
);
  // R1
  key_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_o != '0);

  // R2
  descend_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_descend |=> key_o[KW-1:1] == $past(key_o[KW-2:0]));

  // R3
  descend_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_descend |=> (trail_o[0] == $past(hit_l_i && hit_r_i)) && (trail_o[KW-1:1] == $past(trail_o[KW-2:0])));

  // R4
  postpone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_descend && hit_l_i && hit_r_i) |=> pp_valid_o && (pp_addr_o == $past(closer_r_i ? left_addr_i : right_addr_i)));

  // R6
  backstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_backstep |=> bt_valid_o && !trail_o[0] && ($countones(trail_o) == $countones($past(trail_o)) - 1));

  // R7
  cached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_backstep && pp_valid_o) |=> bt_cached_o && !pp_valid_o && (bt_addr_o == $past(pp_addr_o)));

  // R8
  target_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bt_valid_o |-> bt_key_o == key_o);

  // R9
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> trail_o == '0);

  // R11
  overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> ovf_o && $stable(key_o) && $stable(trail_o));
endmodule

bind trav_state_unit trav_state_chk #(.KW(KW), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hit_l_i      (hit_l_i),
  .hit_r_i      (hit_r_i),
  .closer_r_i   (closer_r_i),
  .left_addr_i  (left_addr_i),
  .right_addr_i (right_addr_i),
  .key_o        (key_o),
  .trail_o      (trail_o),
  .pp_valid_o   (pp_valid_o),
  .pp_addr_o    (pp_addr_o),
  .bt_valid_o   (bt_valid_o),
  .bt_cached_o  (bt_cached_o),
  .bt_addr_o    (bt_addr_o),
  .bt_key_o     (bt_key_o),
  .done_o       (done_o),
  .ovf_o        (ovf_o),
  .ev_descend   (ev_descend),
  .ev_overflow  (ev_overflow),
  .ev_backstep  (ev_backstep)
);

// File: tb/trav_state_unit_test.sv
module trav_state_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic        hit_l_i = 1'b0, hit_r_i = 1'b0, closer_r_i = 1'b0;
  logic [31:0] left_addr_i = '0, right_addr_i = '0, uncle_i = '0, guncle_i = '0, resume_key_i = '0;
  logic [31:0] key_o, trail_o, pp_addr_o, bt_addr_o, bt_key_o;
  logic        pp_valid_o, bt_valid_o, bt_cached_o, done_o, ovf_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  trav_state_unit uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i),
    .hit_l_i(hit_l_i), .hit_r_i(hit_r_i), .closer_r_i(closer_r_i),
    .left_addr_i(left_addr_i), .right_addr_i(right_addr_i),
    .uncle_i(uncle_i), .guncle_i(guncle_i), .resume_key_i(resume_key_i),
    .key_o(key_o), .trail_o(trail_o), .pp_valid_o(pp_valid_o), .pp_addr_o(pp_addr_o),
    .bt_valid_o(bt_valid_o), .bt_cached_o(bt_cached_o), .bt_addr_o(bt_addr_o),
    .bt_key_o(bt_key_o), .done_o(done_o), .ovf_o(ovf_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Apply one command at the falling edge, return at the next falling edge.
  task automatic tick(input logic [2:0] op);
    op_i = op;
    @(negedge clk);
    op_i = 3'd0;
  endtask

  task automatic node(input logic hl, input logic hr, input logic cr,
                      input logic [31:0] la, input logic [31:0] ra,
                      input logic [31:0] un, input logic [31:0] gu);
    hit_l_i = hl; hit_r_i = hr; closer_r_i = cr;
    left_addr_i = la; right_addr_i = ra; uncle_i = un; guncle_i = gu;
    tick(3'd2);
    hit_l_i = 1'b0; hit_r_i = 1'b0;
  endtask

  task automatic leaf(input logic [31:0] un, input logic [31:0] gu);
    uncle_i = un; guncle_i = gu;
    tick(3'd3);
  endtask

  task automatic resume(input logic [31:0] k);
    resume_key_i = k;
    tick(3'd5);
  endtask

  task automatic t_reset;
    check("R1 key after reset", key_o, 32'd1);
    check("R1 trail after reset", trail_o, 32'd0);
    check("R1 cache empty", {31'd0, pp_valid_o}, 32'd0);
    check("R1 done/ovf clear", {30'd0, done_o, ovf_o}, 32'd0);
  endtask

  task automatic t_descend_cached;
    tick(3'd1);
    node(1, 1, 0, 32'd10, 32'd11, 32'd0, 32'd0);
    check("R2 key after left", key_o, 32'd2);
    check("R3 trail both hit", trail_o, 32'd1);
    check("R4 far child right", pp_addr_o, 32'd11);
    node(0, 1, 0, 32'd20, 32'd21, 32'd99, 32'd98);
    check("R2 key after right-only", key_o, 32'd5);
    check("R3 trail single hit", trail_o, 32'd2);
    check("R5 full cache kept", pp_addr_o, 32'd11);
    node(1, 1, 1, 32'd30, 32'd31, 32'd0, 32'd0);
    check("R2 key closer right", key_o, 32'd11);
    check("R3 trail", trail_o, 32'd5);
    check("R4 far child left overwrites", pp_addr_o, 32'd30);
    tick(3'd4);
    check("R6 bt pulse", {31'd0, bt_valid_o}, 32'd1);
    check("R6 key ctz0", key_o, 32'd10);
    check("R6 trail ctz0", trail_o, 32'd4);
    check("R7 cached flag", {31'd0, bt_cached_o}, 32'd1);
    check("R7 cached addr", bt_addr_o, 32'd30);
    check("R7 cache emptied", {31'd0, pp_valid_o}, 32'd0);
    leaf(32'd77, 32'd88);
    check("R5 grand-uncle fill", pp_addr_o, 32'd88);
    tick(3'd4);
    check("R6 key ctz2", key_o, 32'd3);
    check("R6 trail ctz2", trail_o, 32'd0);
    check("R7 cached guncle", bt_addr_o, 32'd88);
    tick(3'd0);
    check("R6 pulse ends", {31'd0, bt_valid_o}, 32'd0);
    tick(3'd4);
    check("R9 done", {31'd0, done_o}, 32'd1);
    check("R9 key unchanged", key_o, 32'd3);
    tick(3'd0);
    check("R9 done sticky", {31'd0, done_o}, 32'd1);
  endtask

  task automatic t_resume_hash;
    resume(32'd22);
    check("R10 resume key", key_o, 32'd22);
    check("R10 resume trail", trail_o, 32'd15);
    check("R10 done cleared", {31'd0, done_o}, 32'd0);
    tick(3'd4);
    check("R8 uncached", {31'd0, bt_cached_o}, 32'd0);
    check("R8 lookup key", bt_key_o, 32'd23);
    check("R6 trail", trail_o, 32'd14);
    leaf(32'd55, 32'd66);
    check("R5 uncle fill", pp_addr_o, 32'd55);
    tick(3'd4);
    check("R7 uncle cached", bt_addr_o, 32'd55);
    check("R6 key ctz1", key_o, 32'd10);
    check("R6 trail ctz1", trail_o, 32'd6);
    tick(3'd4);
    check("R8 lookup key 4", bt_key_o, 32'd4);
    check("R8 not cached", {31'd0, bt_cached_o}, 32'd0);
    tick(3'd4);
    check("R8 lookup key 3", bt_key_o, 32'd3);
    check("R6 trail empty", trail_o, 32'd0);
    tick(3'd4);
    check("R9 done after resume walk", {31'd0, done_o}, 32'd1);
  endtask

  task automatic t_resume_ignored;
    resume(32'd6);
    resume(32'd0);
    check("R10 zero key ignored", key_o, 32'd6);
    check("R10 trail kept", trail_o, 32'd3);
    node(1, 0, 0, 32'd1, 32'd2, 32'd9, 32'd8);
    check("R5 node uncle fill", pp_addr_o, 32'd9);
    check("R2 key", key_o, 32'd12);
  endtask

  task automatic t_overflow;
    resume(32'h8000_0000);
    node(1, 0, 0, 32'd1, 32'd2, 32'd0, 32'd0);
    check("R11 ovf set", {31'd0, ovf_o}, 32'd1);
    check("R11 key frozen", key_o, 32'h8000_0000);
    check("R11 trail frozen", trail_o, 32'h7FFF_FFFF);
    check("R11 cache untouched", {31'd0, pp_valid_o}, 32'd0);
    tick(3'd1);
    check("R1 start clears ovf", {31'd0, ovf_o}, 32'd0);
    check("R1 start key", key_o, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_descend_cached();
    t_resume_hash();
    t_resume_ignored();
    t_overflow();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule